// File: doc/BRIEF.md
# Set/Clear Paired Control Register Bank

This block is a 32-bit word-addressed register bank for a system control unit. Each reset-control and clock-stop word has two addresses. A write to the base address sets the bits that are 1 in the data. A write to the alias one word above clears those bits. Two strap words use the same pair scheme, with one difference: a guard word two words above each strap stops set writes while the guard holds a non-zero value. Clear writes to a strap always take effect.

Three PLL extension words always read back with their top bit set, which reports the PLL as locked. A random-data word loads the value on the `rand_word` input each time it is read. Two revision words and the random word ignore writes. A key word stores 1 when it is written with the unlock constant and 0 for any other value. The key never blocks writes to other registers. Every other offset below the map limit is a plain read/write word, and offsets at or above the limit read as zero.

Each access goes through a three-state sequencer. `ST_IDLE` accepts a request and moves to `ST_EXEC` (transition *accept*). `ST_EXEC` updates storage or captures read data and always moves to `ST_RESP` (transition *execute*). `ST_RESP` drives a one-cycle response and always returns to `ST_IDLE` (transition *complete*). The four control words are also driven out as ports, so the reset and clock-gating logic downstream can use them directly.

Top module: `scu_setclr_bank`

## Requirements
- R1: A write to 0x040, 0x050, 0x080 or 0x090 ORs the write data into the word at that offset.
- R2: A write to 0x044, 0x054, 0x084 or 0x094 clears, in the word at the offset minus 4, every bit that is 1 in the data. Reads of these aliases return 0.
- R3: A write to strap 0x500 or 0x510 ORs the data in only while its guard word (0x508 or 0x510+8 = 0x518) reads zero. The guard words are plain read/write. A write to 0x504 or 0x514 clears bits in the strap below it whether or not the guard is set.
- R4: A read of 0x204, 0x224 or 0x244 returns the stored word with bit 31 set to 1.
- R5: Writes to 0x004, 0x014 and 0x540 leave those words unchanged. A read of 0x540 returns the `rand_word` value present in the execute cycle.
- R6: A write to 0x000 stores 1 when the data equals `UNLOCK_WORD`, and stores 0 for any other data. A key value of 0 does not block writes to other offsets.
- R7: After reset, the following values hold: 0x040=0xF7CFFFDC, 0x050=0xFFFFFFFC, 0x080=0xEFF43E8B, 0x090=0xFFF0FFF0, 0x100=0x00000040, 0x200=0x1000405F. Offset 0x004 holds `rev_a_init`, 0x014 holds `rev_b_init`, 0x500 holds `strap_a_init`, 0x510 holds `strap_b_init` and 0x000 holds `key_init`. All other words hold 0.
- R8: Any other word-aligned offset below `MAP_BYTES` (default 0x580) is plain read/write. Reads at or above `MAP_BYTES` return 0, and writes there change nothing.
- R9: A request is accepted only while `req_ready` is high. `req_ready` is then low for two cycles, and `rsp_valid` is high for exactly one cycle, in the second cycle after acceptance. `rsp_rdata` carries read data with a read response and 0 with a write response.
- R10: `rst_ctl0`, `rst_ctl1`, `clk_stop0` and `clk_stop1` always equal the words at 0x040, 0x050, 0x080 and 0x090. They change only on the clock edge that ends the execute cycle of a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset, word aligned |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_rdata | output | 32 | Read data (0 for write responses) |
| rand_word | input | 32 | Entropy word loaded on a random-word read |
| rev_a_init | input | 32 | Reset load for the revision word at 0x004 |
| rev_b_init | input | 32 | Reset load for the revision word at 0x014 |
| strap_a_init | input | 32 | Reset load for strap 0x500 |
| strap_b_init | input | 32 | Reset load for strap 0x510 |
| key_init | input | 32 | Reset load for the key word |
| rst_ctl0 | output | 32 | Word at 0x040 |
| rst_ctl1 | output | 32 | Word at 0x050 |
| clk_stop0 | output | 32 | Word at 0x080 |
| clk_stop1 | output | 32 | Word at 0x090 |

## Verification
The bench covers the following corner cases, each of which a faulty design would fail:
- **Clear alias landing on the wrong word.** The bench writes the clear aliases and checks that only the word one address below changes. A decoder that wrote the alias itself, or a neighbouring word, would leave the control port unchanged or corrupt another word.
- **Strap guard.** The bench sets a guard word, tries a strap set write, clears strap bits while the guard is still set, then lowers the guard and sets again. A design that gated clears as well, or checked the wrong guard word, shows a stale strap value on the next read.
- **Read-time effects.** The bench reads the random word with two different entropy values and reads PLL words whose stored bit 31 is zero. A design that sampled entropy in the wrong cycle or forced the bit on write would return values that do not match.
- **Key and map limit.** Mismatched keys must read back as 0, writes must still land after a zero key, and offsets past the limit must stay at 0 after a write.

// File: rtl/scu_pkg.sv
package scu_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EXEC = 2'd1,
        ST_RESP = 2'd2
    } bus_state_t;

    typedef enum logic [3:0] {
        K_PLAIN,
        K_KEY,
        K_RDONLY,
        K_SET,
        K_CLR,
        K_STRAP_SET,
        K_STRAP_CLR,
        K_PLL_EXT,
        K_RAND,
        K_OUTSIDE
    } reg_kind_t;

    // byte offsets whose behaviour is decoded
    localparam int unsigned OFS_KEY     = 32'h000;
    localparam int unsigned OFS_REV_A   = 32'h004;
    localparam int unsigned OFS_REV_B   = 32'h014;
    localparam int unsigned OFS_RSTC0   = 32'h040;
    localparam int unsigned OFS_RSTC1   = 32'h050;
    localparam int unsigned OFS_CLKS0   = 32'h080;
    localparam int unsigned OFS_CLKS1   = 32'h090;
    localparam int unsigned OFS_DRAMOK  = 32'h100;
    localparam int unsigned OFS_PLL_H   = 32'h200;
    localparam int unsigned OFS_PLLX_H  = 32'h204;
    localparam int unsigned OFS_PLLX_M  = 32'h224;
    localparam int unsigned OFS_PLLX_E  = 32'h244;
    localparam int unsigned OFS_STRAP_A = 32'h500;
    localparam int unsigned OFS_STRAP_B = 32'h510;
    localparam int unsigned OFS_RAND    = 32'h540;

    // distance from a set word to its clear alias and guard word
    localparam int unsigned CLR_STEP   = 4;
    localparam int unsigned GUARD_STEP = 8;

    localparam logic [31:0] BOOT_RSTC0  = 32'hF7CF_FFDC;
    localparam logic [31:0] BOOT_RSTC1  = 32'hFFFF_FFFC;
    localparam logic [31:0] BOOT_CLKS0  = 32'hEFF4_3E8B;
    localparam logic [31:0] BOOT_CLKS1  = 32'hFFF0_FFF0;
    localparam logic [31:0] BOOT_DRAMOK = 32'h0000_0040;
    localparam logic [31:0] BOOT_PLL_H  = 32'h1000_405F;

endpackage

// File: rtl/scu_addr_decode.sv
module scu_addr_decode
    import scu_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int MAP_BYTES = 32'h580,
    localparam int MAP_WORDS = MAP_BYTES / 4,
    localparam int IDX_W     = $clog2(MAP_WORDS)
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_kind_t         kind,
    output logic [IDX_W-1:0]  own_idx,
    output logic [IDX_W-1:0]  tgt_idx,
    output logic [IDX_W-1:0]  guard_idx
);

    logic [31:0] addr_ext;
    assign addr_ext = 32'(addr);

    always_comb begin
        if (addr_ext >= 32'(MAP_BYTES)) begin
            kind = K_OUTSIDE;
        end else begin
            case (addr_ext)
                OFS_KEY:                              kind = K_KEY;
                OFS_REV_A, OFS_REV_B, OFS_RAND - 0:   kind = (addr_ext == OFS_RAND) ? K_RAND : K_RDONLY;
                OFS_RSTC0, OFS_RSTC1,
                OFS_CLKS0, OFS_CLKS1:                 kind = K_SET;
                OFS_RSTC0 + CLR_STEP, OFS_RSTC1 + CLR_STEP,
                OFS_CLKS0 + CLR_STEP, OFS_CLKS1 + CLR_STEP: kind = K_CLR;
                OFS_STRAP_A, OFS_STRAP_B:             kind = K_STRAP_SET;
                OFS_STRAP_A + CLR_STEP,
                OFS_STRAP_B + CLR_STEP:               kind = K_STRAP_CLR;
                OFS_PLLX_H, OFS_PLLX_M, OFS_PLLX_E:   kind = K_PLL_EXT;
                default:                              kind = K_PLAIN;
            endcase
        end
    end

    assign own_idx = addr[IDX_W+1:2];

    always_comb begin
        tgt_idx   = own_idx;
        guard_idx = own_idx;
        if (kind == K_CLR || kind == K_STRAP_CLR) begin
            tgt_idx = own_idx - IDX_W'(CLR_STEP / 4);
        end
        if (kind == K_STRAP_SET) begin
            guard_idx = own_idx + IDX_W'(GUARD_STEP / 4);
        end
    end

endmodule

// File: rtl/scu_wr_merge.sv
module scu_wr_merge
    import scu_pkg::*;
#(
    parameter int          DATA_W      = 32,
    parameter logic [31:0] UNLOCK_WORD = 32'hC0DE_5A5A
) (
    input  logic              exec_wr,
    input  reg_kind_t         kind,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] tgt_cur,
    input  logic [DATA_W-1:0] guard_cur,
    output logic              wr_en,
    output logic [DATA_W-1:0] wr_val
);

    always_comb begin
        wr_en  = 1'b0;
        wr_val = tgt_cur;
        if (exec_wr) begin
            unique case (kind)
                K_KEY: begin
                    wr_en  = 1'b1;
                    wr_val = (wdata == DATA_W'(UNLOCK_WORD)) ? DATA_W'(1) : '0;
                end
                K_SET: begin
                    wr_en  = 1'b1;
                    wr_val = tgt_cur | wdata;
                end
                K_CLR, K_STRAP_CLR: begin
                    wr_en  = 1'b1;
                    wr_val = tgt_cur & ~wdata;
                end
                K_STRAP_SET: begin
                    wr_en  = (guard_cur == '0);
                    wr_val = tgt_cur | wdata;
                end
                K_PLAIN, K_PLL_EXT: begin
                    wr_en  = 1'b1;
                    wr_val = wdata;
                end
                default: begin
                    wr_en  = 1'b0;
                    wr_val = tgt_cur;
                end
            endcase
        end
    end

endmodule

// File: rtl/scu_rd_mux.sv
module scu_rd_mux
    import scu_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int LOCK_BIT = DATA_W - 1
) (
    input  reg_kind_t         kind,
    input  logic [DATA_W-1:0] own_cur,
    input  logic [DATA_W-1:0] rand_word,
    output logic [DATA_W-1:0] rd_val
);

    always_comb begin
        unique case (kind)
            K_OUTSIDE: rd_val = '0;
            K_PLL_EXT: rd_val = own_cur | (DATA_W'(1) << LOCK_BIT);
            K_RAND:    rd_val = rand_word;
            default:   rd_val = own_cur;
        endcase
    end

endmodule

// File: rtl/scu_setclr_bank.sv
module scu_setclr_bank
    import scu_pkg::*;
#(
    parameter int          DATA_W      = 32,
    parameter int          ADDR_W      = 12,
    parameter int          MAP_BYTES   = 32'h580,
    parameter logic [31:0] UNLOCK_WORD = 32'hC0DE_5A5A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    input  logic [DATA_W-1:0] rand_word,
    input  logic [DATA_W-1:0] rev_a_init,
    input  logic [DATA_W-1:0] rev_b_init,
    input  logic [DATA_W-1:0] strap_a_init,
    input  logic [DATA_W-1:0] strap_b_init,
    input  logic [DATA_W-1:0] key_init,
    output logic [DATA_W-1:0] rst_ctl0,
    output logic [DATA_W-1:0] rst_ctl1,
    output logic [DATA_W-1:0] clk_stop0,
    output logic [DATA_W-1:0] clk_stop1
);

    localparam int MAP_WORDS = MAP_BYTES / 4;
    localparam int IDX_W     = $clog2(MAP_WORDS);
    localparam int W_KEY     = OFS_KEY / 4;
    localparam int W_REV_A   = OFS_REV_A / 4;
    localparam int W_REV_B   = OFS_REV_B / 4;
    localparam int W_RSTC0   = OFS_RSTC0 / 4;
    localparam int W_RSTC1   = OFS_RSTC1 / 4;
    localparam int W_CLKS0   = OFS_CLKS0 / 4;
    localparam int W_CLKS1   = OFS_CLKS1 / 4;
    localparam int W_DRAMOK  = OFS_DRAMOK / 4;
    localparam int W_PLL_H   = OFS_PLL_H / 4;
    localparam int W_STRAP_A = OFS_STRAP_A / 4;
    localparam int W_STRAP_B = OFS_STRAP_B / 4;

    bus_state_t        state;
    bus_state_t        state_nxt;
    logic              lat_write;
    logic [ADDR_W-1:0] lat_addr;
    logic [DATA_W-1:0] lat_wdata;
    logic [DATA_W-1:0] rdata_q;

    logic [DATA_W-1:0] bank [MAP_WORDS];

    reg_kind_t         kind;
    logic [IDX_W-1:0]  own_idx;
    logic [IDX_W-1:0]  tgt_idx;
    logic [IDX_W-1:0]  guard_idx;
    logic              exec_wr;
    logic              exec_rd;
    logic              wr_en;
    logic [DATA_W-1:0] wr_val;
    logic [DATA_W-1:0] rd_val;
    logic [DATA_W-1:0] own_cur;
    logic [DATA_W-1:0] tgt_cur;
    logic [DATA_W-1:0] guard_cur;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // transitions: accept, execute, complete
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: if (req_valid) state_nxt = ST_EXEC;
            ST_EXEC: state_nxt = ST_RESP;
            ST_RESP: state_nxt = ST_IDLE;
            default: state_nxt = ST_IDLE;
        endcase
    end

    // outputs of the sequencer
    always_comb begin
        req_ready = (state == ST_IDLE);
        rsp_valid = (state == ST_RESP);
        exec_wr   = (state == ST_EXEC) && lat_write;
        exec_rd   = (state == ST_EXEC) && !lat_write;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_write <= 1'b0;
            lat_addr  <= '0;
            lat_wdata <= '0;
        end else if (state == ST_IDLE && req_valid) begin
            lat_write <= req_write;
            lat_addr  <= req_addr;
            lat_wdata <= req_wdata;
        end
    end

    scu_addr_decode #(
        .ADDR_W    (ADDR_W),
        .MAP_BYTES (MAP_BYTES)
    ) u_decode (
        .addr      (lat_addr),
        .kind      (kind),
        .own_idx   (own_idx),
        .tgt_idx   (tgt_idx),
        .guard_idx (guard_idx)
    );

    always_comb begin
        own_cur   = (kind == K_OUTSIDE) ? '0 : bank[own_idx];
        tgt_cur   = (kind == K_OUTSIDE) ? '0 : bank[tgt_idx];
        guard_cur = (kind == K_OUTSIDE) ? '0 : bank[guard_idx];
    end

    scu_wr_merge #(
        .DATA_W      (DATA_W),
        .UNLOCK_WORD (UNLOCK_WORD)
    ) u_merge (
        .exec_wr   (exec_wr),
        .kind      (kind),
        .wdata     (lat_wdata),
        .tgt_cur   (tgt_cur),
        .guard_cur (guard_cur),
        .wr_en     (wr_en),
        .wr_val    (wr_val)
    );

    scu_rd_mux #(
        .DATA_W (DATA_W)
    ) u_rdmux (
        .kind      (kind),
        .own_cur   (own_cur),
        .rand_word (rand_word),
        .rd_val    (rd_val)
    );

    // storage with boot values
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MAP_WORDS; i++) begin
                bank[i] <= '0;
            end
            bank[W_KEY]     <= key_init;
            bank[W_REV_A]   <= rev_a_init;
            bank[W_REV_B]   <= rev_b_init;
            bank[W_RSTC0]   <= DATA_W'(BOOT_RSTC0);
            bank[W_RSTC1]   <= DATA_W'(BOOT_RSTC1);
            bank[W_CLKS0]   <= DATA_W'(BOOT_CLKS0);
            bank[W_CLKS1]   <= DATA_W'(BOOT_CLKS1);
            bank[W_DRAMOK]  <= DATA_W'(BOOT_DRAMOK);
            bank[W_PLL_H]   <= DATA_W'(BOOT_PLL_H);
            bank[W_STRAP_A] <= strap_a_init;
            bank[W_STRAP_B] <= strap_b_init;
        end else begin
            if (wr_en) begin
                bank[tgt_idx] <= wr_val;
            end
            if (exec_rd && kind == K_RAND) begin
                bank[own_idx] <= rand_word;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (state == ST_EXEC) begin
            rdata_q <= lat_write ? '0 : rd_val;
        end
    end

    assign rsp_rdata = rdata_q;
    assign rst_ctl0  = bank[W_RSTC0];
    assign rst_ctl1  = bank[W_RSTC1];
    assign clk_stop0 = bank[W_CLKS0];
    assign clk_stop1 = bank[W_CLKS1];

endmodule

// File: rtl/scu_setclr_bank_chk.sv
module scu_setclr_bank_chk
    import scu_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 12,
    parameter int MAP_BYTES = 32'h580
) (
    input logic              clk,
    input logic              rst_n,
    input bus_state_t        state,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic              lat_write,
    input logic [ADDR_W-1:0] lat_addr,
    input logic [DATA_W-1:0] lat_wdata,
    input logic [DATA_W-1:0] rand_word,
    input logic [DATA_W-1:0] rst_ctl0,
    input logic [DATA_W-1:0] clk_stop1
);

    logic exec_wr;
    logic rd_resp;
    assign exec_wr = (state == ST_EXEC) && lat_write;
    assign rd_resp = rsp_valid && !lat_write;

    p_rsp_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    p_busy_after_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid) |=> !req_ready);

    p_rsp_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid) |=> ##1 rsp_valid);

    p_set_or_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_wr && lat_addr == ADDR_W'(OFS_RSTC0))
        |=> (rst_ctl0 == ($past(rst_ctl0) | $past(lat_wdata))));

    p_clear_alias_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_wr && lat_addr == ADDR_W'(OFS_CLKS1 + CLR_STEP))
        |=> (clk_stop1 == ($past(clk_stop1) & ~$past(lat_wdata))));

    p_ctl_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_wr |=> ($stable(rst_ctl0) && $stable(clk_stop1)));

    p_pll_lock_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_resp && (lat_addr == ADDR_W'(OFS_PLLX_H) || lat_addr == ADDR_W'(OFS_PLLX_M)
                     || lat_addr == ADDR_W'(OFS_PLLX_E)))
        |-> rsp_rdata[DATA_W-1]);

    p_rand_fresh_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_resp && lat_addr == ADDR_W'(OFS_RAND)) |-> (rsp_rdata == $past(rand_word)));

    p_outside_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_resp && 32'(lat_addr) >= 32'(MAP_BYTES)) |-> (rsp_rdata == '0));

endmodule

bind scu_setclr_bank scu_setclr_bank_chk #(
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .MAP_BYTES (MAP_BYTES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (state),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .lat_write (lat_write),
    .lat_addr  (lat_addr),
    .lat_wdata (lat_wdata),
    .rand_word (rand_word),
    .rst_ctl0  (rst_ctl0),
    .clk_stop1 (clk_stop1)
);

// File: tb/scu_setclr_bank_tb.sv
module scu_setclr_bank_tb;

    localparam logic [31:0] KEY = 32'hC0DE_5A5A;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        req_ready;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic [31:0] rand_word = 32'h1357_9BDF;
    logic [31:0] rev_a_init = 32'hA1B2_0001;
    logic [31:0] rev_b_init = 32'hA1B2_0002;
    logic [31:0] strap_a_init = 32'h0000_0C01;
    logic [31:0] strap_b_init = 32'h0000_0002;
    logic [31:0] key_init = 32'h0;
    logic [31:0] rst_ctl0, rst_ctl1, clk_stop0, clk_stop1;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [31:0] mdl [int];

    always #5 clk = ~clk;

    scu_setclr_bank u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rand_word(rand_word),
        .rev_a_init(rev_a_init), .rev_b_init(rev_b_init), .strap_a_init(strap_a_init),
        .strap_b_init(strap_b_init), .key_init(key_init), .rst_ctl0(rst_ctl0),
        .rst_ctl1(rst_ctl1), .clk_stop0(clk_stop0), .clk_stop1(clk_stop1)
    );

    function automatic logic [31:0] mget(int a);
        return mdl.exists(a / 4) ? mdl[a / 4] : 32'h0;
    endfunction

    task automatic mset(int a, logic [31:0] v);
        mdl[a / 4] = v;
    endtask

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic mdl_boot();
        mdl.delete();
        mset('h000, key_init);
        mset('h004, rev_a_init);
        mset('h014, rev_b_init);
        mset('h040, 32'hF7CF_FFDC);
        mset('h050, 32'hFFFF_FFFC);
        mset('h080, 32'hEFF4_3E8B);
        mset('h090, 32'hFFF0_FFF0);
        mset('h100, 32'h0000_0040);
        mset('h200, 32'h1000_405F);
        mset('h500, strap_a_init);
        mset('h510, strap_b_init);
    endtask

    // behavioural reference of one access
    task automatic mdl_access(bit w, int a, logic [31:0] d, output logic [31:0] e);
        e = 32'h0;
        if (a >= 'h580) return;
        if (w) begin
            if (a == 'h000) mset(a, (d == KEY) ? 32'h1 : 32'h0);
            else if (a == 'h004 || a == 'h014 || a == 'h540) begin end
            else if (a == 'h040 || a == 'h050 || a == 'h080 || a == 'h090) mset(a, mget(a) | d);
            else if (a == 'h044 || a == 'h054 || a == 'h084 || a == 'h094 ||
                     a == 'h504 || a == 'h514) mset(a - 4, mget(a - 4) & ~d);
            else if (a == 'h500 || a == 'h510) begin
                if (mget(a + 8) == 0) mset(a, mget(a) | d);
            end
            else mset(a, d);
        end else begin
            if (a == 'h204 || a == 'h224 || a == 'h244) e = mget(a) | 32'h8000_0000;
            else if (a == 'h540) begin
                mset(a, rand_word);
                e = rand_word;
            end
            else e = mget(a);
        end
    endtask

    // R10: control ports compared with the reference on every clock
    task automatic tick();
        @(negedge clk);
        chk("R10 rst_ctl0", rst_ctl0, mget('h040));
        chk("R10 rst_ctl1", rst_ctl1, mget('h050));
        chk("R10 clk_stop0", clk_stop0, mget('h080));
        chk("R10 clk_stop1", clk_stop1, mget('h090));
    endtask

    task automatic acc(bit w, int a, logic [31:0] d, string tag);
        logic [31:0] e;
        req_valid = 1'b1;
        req_write = w;
        req_addr  = a[11:0];
        req_wdata = d;
        tick();
        req_valid = 1'b0;
        chk({tag, " R9 busy"}, 32'(req_ready), 32'h0);
        chk({tag, " R9 no early rsp"}, 32'(rsp_valid), 32'h0);
        mdl_access(w, a, d, e);
        tick();
        chk({tag, " R9 rsp"}, 32'(rsp_valid), 32'h1);
        chk({tag, " data"}, rsp_rdata, e);
        tick();
        chk({tag, " R9 rsp end"}, 32'(rsp_valid), 32'h0);
        chk({tag, " R9 ready"}, 32'(req_ready), 32'h1);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R9 watchdog actual=hung expected=complete");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        mdl_boot();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();
        // R7 reset state at the ports and through reads
        chk("R7 rst_ctl0 boot", rst_ctl0, 32'hF7CF_FFDC);
        chk("R7 clk_stop1 boot", clk_stop1, 32'hFFF0_FFF0);
        chk("R7 ready boot", 32'(req_ready), 32'h1);
        chk("R7 rsp idle boot", 32'(rsp_valid), 32'h0);
        acc(0, 'h100, 0, "R7 dram word");
        acc(0, 'h200, 0, "R7 pll word");
        acc(0, 'h004, 0, "R7 rev a");
        acc(0, 'h014, 0, "R7 rev b");
        acc(0, 'h500, 0, "R7 strap a");
        acc(0, 'h510, 0, "R7 strap b");
        acc(0, 'h000, 0, "R7 key");
        acc(0, 'h300, 0, "R7 plain zero");
        // R1 set
        acc(1, 'h040, 32'h0800_0123, "R1 set rst0");
        acc(1, 'h050, 32'h0000_0003, "R1 set rst1");
        acc(1, 'h080, 32'h1000_4174, "R1 set clk0");
        acc(1, 'h090, 32'h000F_0000, "R1 set clk1");
        acc(0, 'h040, 0, "R1 read rst0");
        // R2 clear aliases
        acc(1, 'h044, 32'hF000_0001, "R2 clr rst0");
        acc(1, 'h054, 32'h0000_FF00, "R2 clr rst1");
        acc(1, 'h084, 32'hFFFF_FFFF, "R2 clr clk0");
        acc(1, 'h094, 32'h8000_0010, "R2 clr clk1");
        acc(0, 'h044, 0, "R2 alias reads zero");
        acc(0, 'h090, 0, "R2 read clk1");
        // R3 strap guard
        acc(1, 'h500, 32'h0000_00F0, "R3 set a open");
        acc(1, 'h508, 32'h0000_0001, "R3 guard a on");
        acc(0, 'h508, 0, "R3 guard a read");
        acc(1, 'h500, 32'hFF00_0000, "R3 set a blocked");
        acc(0, 'h500, 0, "R3 read a blocked");
        acc(1, 'h504, 32'h0000_0011, "R3 clr a guarded");
        acc(0, 'h500, 0, "R3 read a cleared");
        acc(1, 'h508, 32'h0, "R3 guard a off");
        acc(1, 'h500, 32'h0F00_0000, "R3 set a reopen");
        acc(0, 'h500, 0, "R3 read a reopen");
        acc(1, 'h518, 32'h8000_0000, "R3 guard b on");
        acc(1, 'h510, 32'h0000_00FF, "R3 set b blocked");
        acc(1, 'h514, 32'h0000_0002, "R3 clr b guarded");
        acc(0, 'h510, 0, "R3 read b");
        acc(1, 'h500, 32'h0000_0100, "R3 a open while b guarded");
        acc(0, 'h500, 0, "R3 read a independent");
        // R4 lock bit on read
        acc(1, 'h204, 32'h0000_1234, "R4 write pll h");
        acc(0, 'h204, 0, "R4 read pll h");
        acc(0, 'h224, 0, "R4 read pll m");
        acc(1, 'h244, 32'h8000_0005, "R4 write pll e");
        acc(0, 'h244, 0, "R4 read pll e");
        // R5 read-only words and entropy
        acc(1, 'h004, 32'hDEAD_BEEF, "R5 write rev a");
        acc(0, 'h004, 0, "R5 rev a kept");
        acc(1, 'h014, 32'h0, "R5 write rev b");
        acc(0, 'h014, 0, "R5 rev b kept");
        acc(0, 'h540, 0, "R5 rand first");
        rand_word = 32'h2468_ACE0;
        acc(0, 'h540, 0, "R5 rand second");
        acc(1, 'h540, 32'hFFFF_FFFF, "R5 write rand");
        rand_word = 32'h0F0F_5555;
        acc(0, 'h540, 0, "R5 rand third");
        // R6 key
        acc(1, 'h000, 32'h0000_1234, "R6 bad key");
        acc(0, 'h000, 0, "R6 read bad key");
        acc(1, 'h300, 32'hA5A5_A5A5, "R6 write with zero key");
        acc(0, 'h300, 0, "R6 not blocked");
        acc(1, 'h000, KEY, "R6 good key");
        acc(0, 'h000, 0, "R6 read good key");
        acc(1, 'h000, KEY ^ 32'h1, "R6 near key");
        acc(0, 'h000, 0, "R6 read near key");
        // R8 plain words and map limit
        acc(1, 'h57C, 32'h7777_0001, "R8 last plain");
        acc(0, 'h57C, 0, "R8 read last plain");
        acc(1, 'h100, 32'h0000_0000, "R8 dram plain");
        acc(0, 'h100, 0, "R8 read dram plain");
        acc(1, 'h580, 32'hFFFF_FFFF, "R8 write at limit");
        acc(0, 'h580, 0, "R8 read at limit");
        acc(1, 'hFFC, 32'h1234_5678, "R8 write top");
        acc(0, 'hFFC, 0, "R8 read top");
        acc(0, 'h050, 0, "R8 rst1 untouched");
        // R7 reset again restores boot values
        rst_n = 1'b0;
        mdl_boot();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        tick();
        acc(0, 'h508, 0, "R7 guard cleared by reset");
        acc(0, 'h000, 0, "R7 key reloaded");
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule